// File: doc/BRIEF.md
# Interval Timer Host Access Logic

This block is the processor-facing side of a three-channel interval timer. A byte-wide bus reaches four addresses. Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. Address 3 is the command port. The block turns bus writes into programming outputs for each channel: the operating mode, a BCD flag, a 16-bit initial count and a one-cycle load strobe. The counting engine that consumes these outputs sits outside this block. That engine returns each channel's live count, its output level and its null-count flag. From these the block builds the bytes that software reads back.

The command port accepts three kinds of write. A control word sets up one counter. A latch command freezes one counter's count. A read-back command snapshots the count, the status, or both, for any group of counters. Each counter has its own byte pointers for writes and for reads. Two-byte transfers to different counters can therefore be interleaved. Frozen values stay held until software has consumed them.

Read data is combinational from the address and the current state. A read advances the state at the clock edge where `bus_rd` is sampled high. When `bus_wr` and `bus_rd` are both high in the same cycle, the write is taken and the read has no effect.

Top module: `timer_host_regs`

## Requirements
- R1: After reset every channel has mode 0, BCD 0, initial count 0 and load low, and its access format is low-byte-only. A read of a data port then returns the low byte of that channel's live count.
- R2: A write to address 3 with bits 7:6 = n (0 to 2) and bits 5:4 non-zero is a control word for counter n. It sets that counter's mode from bits 3:1, BCD from bit 0 and access format from bits 5:4, and the new values appear on the outputs in the next cycle. No other counter changes and no load strobe is produced.
- R3: Access format 01 = low byte only, 10 = high byte only, 11 = low byte then high byte. A data-port write places its byte according to the format, with the other byte zero for single-byte formats. One cycle after the write that completes the count, the load strobe of that counter pulses for one cycle while the initial-count output shows the new value. Reads follow the same format.
- R4: Each counter keeps its own write-byte and read-byte position, so two-byte writes and reads to different counters may be interleaved without disturbing each other.
- R5: A command-port write with bits 5:4 = 00 and bits 7:6 = n freezes a copy of counter n's live count. Reads return the copy until all bytes of the format have been read, and return the live count after that.
- R6: A latch command to a counter whose frozen count has not yet been read is ignored.
- R7: A command-port write with bits 7:6 = 11 is a read-back. Bit 5 low freezes the count, bit 4 low freezes the status, and bits 1, 2 and 3 select counters 0, 1 and 2. A repeated count or status capture on a counter that still holds an unread one is ignored.
- R8: The status byte is {OUT, null count, access format[1:0], mode[2:0], BCD}, from bit 7 down to bit 0, sampled when the read-back is written.
- R9: When a counter holds a frozen status, the next read returns the status regardless of capture order. The following one or two reads (per format) return the frozen count, and later reads return the live count.
- R10: A control word to a counter discards its frozen count and status and resets its read and write byte positions to the low byte.
- R11: A read of address 3 returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port select: 0 to 2 counter data, 3 command |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; consumed at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| chan_mode | output | 9 | Mode of each channel, 3 bits per channel |
| chan_bcd | output | 3 | BCD counting select per channel |
| chan_init | output | 48 | Initial count per channel, 16 bits each |
| chan_load | output | 3 | One-cycle strobe: new initial count is valid |
| chan_count | input | 48 | Live count per channel, 16 bits each |
| chan_out | input | 3 | Output level per channel |
| chan_null | input | 3 | Null-count flag per channel |

## Verification
The case that needs most care is a counter holding a frozen status and a frozen count at the same time. The read stream must then give the status, then the count bytes, then live data. This case is set up both with one read-back that captures both values in the same write and with a count capture followed later by a status capture. Between the capture and the reads the bench changes the live count. It then compares every byte read against values worked out by hand, which shows that the status comes first, that the frozen count was not overwritten, and that the live count is returned once both frozen values are used up.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_LOHI  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic ctl;
        logic latch;
        logic rb_cnt;
        logic rb_st;
        logic wr;
        logic rd;
    } chan_cmd_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              bcd;
        fmt_e              fmt;
        logic [CNT_W-1:0]  init;
        logic              load;
        logic              wr_hi;
        logic              rd_hi;
        logic              cnt_lat;
        logic [CNT_W-1:0]  cnt_val;
        logic              st_lat;
        logic [BYTE_W-1:0] st_val;
    } chan_state_t;
endpackage

// File: rtl/thr_cmd_decode.sv
module thr_cmd_decode
    import thr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:1]     cmd_bits,
    output chan_cmd_t [NCH-1:0]   cmd
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

    logic ctl_port;
    logic is_rb;

    always_comb begin
        ctl_port = bus_wr && (bus_addr == CTL_ADDR);
        is_rb    = (cmd_bits[7:6] == 2'b11);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic sel;
        always_comb begin
            sel             = (cmd_bits[7:6] == 2'(i));
            cmd[i].ctl      = ctl_port && !is_rb && sel && (cmd_bits[5:4] != 2'b00);
            cmd[i].latch    = ctl_port && !is_rb && sel && (cmd_bits[5:4] == 2'b00);
            cmd[i].rb_cnt   = ctl_port && is_rb && cmd_bits[1+i] && !cmd_bits[5];
            cmd[i].rb_st    = ctl_port && is_rb && cmd_bits[1+i] && !cmd_bits[4];
            cmd[i].wr       = bus_wr && (bus_addr == AW'(i));
            cmd[i].rd       = bus_rd && !bus_wr && (bus_addr == AW'(i));
        end
    end
endmodule

// File: rtl/thr_channel.sv
module thr_channel
    import thr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  chan_cmd_t          cmd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   live_cnt,
    input  logic               live_out,
    input  logic               live_null,
    output logic [MODE_W-1:0]  mode,
    output logic               bcd,
    output logic [CNT_W-1:0]   init,
    output logic               load,
    output logic [BYTE_W-1:0]  rd_byte
);
    chan_state_t s_d, s_q;
    logic [CNT_W-1:0] src_d;
    logic             rd_done_d;

    // read byte selection: status has priority over count
    always_comb begin
        src_d = s_q.cnt_lat ? s_q.cnt_val : live_cnt;
        if (s_q.st_lat) begin
            rd_byte = s_q.st_val;
        end else begin
            unique case (s_q.fmt)
                FMT_HI:   rd_byte = src_d[CNT_W-1:BYTE_W];
                FMT_LOHI: rd_byte = s_q.rd_hi ? src_d[CNT_W-1:BYTE_W] : src_d[BYTE_W-1:0];
                default:  rd_byte = src_d[BYTE_W-1:0];
            endcase
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.load  = 1'b0;
        rd_done_d = 1'b0;

        if (cmd.ctl) begin
            s_d.mode    = wdata[3:1];
            s_d.bcd     = wdata[0];
            s_d.fmt     = fmt_e'(wdata[5:4]);
            s_d.wr_hi   = 1'b0;
            s_d.rd_hi   = 1'b0;
            s_d.cnt_lat = 1'b0;
            s_d.st_lat  = 1'b0;
        end

        if ((cmd.latch || cmd.rb_cnt) && !s_q.cnt_lat) begin
            s_d.cnt_lat = 1'b1;
            s_d.cnt_val = live_cnt;
        end

        if (cmd.rb_st && !s_q.st_lat) begin
            s_d.st_lat = 1'b1;
            s_d.st_val = {live_out, live_null, s_q.fmt, s_q.mode, s_q.bcd};
        end

        if (cmd.wr) begin
            unique case (s_q.fmt)
                FMT_LO: begin
                    s_d.init = {{BYTE_W{1'b0}}, wdata};
                    s_d.load = 1'b1;
                end
                FMT_HI: begin
                    s_d.init = {wdata, {BYTE_W{1'b0}}};
                    s_d.load = 1'b1;
                end
                FMT_LOHI: begin
                    if (s_q.wr_hi) begin
                        s_d.init[CNT_W-1:BYTE_W] = wdata;
                        s_d.wr_hi                = 1'b0;
                        s_d.load                 = 1'b1;
                    end else begin
                        s_d.init[BYTE_W-1:0] = wdata;
                        s_d.wr_hi            = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (cmd.rd) begin
            if (s_q.st_lat) begin
                s_d.st_lat = 1'b0;
            end else begin
                if (s_q.fmt == FMT_LOHI) begin
                    s_d.rd_hi = !s_q.rd_hi;
                    rd_done_d = s_q.rd_hi;
                end else begin
                    rd_done_d = 1'b1;
                end
                if (rd_done_d) s_d.cnt_lat = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: '0, bcd: 1'b0, fmt: FMT_LO, init: '0, load: 1'b0,
                     wr_hi: 1'b0, rd_hi: 1'b0, cnt_lat: 1'b0, cnt_val: '0,
                     st_lat: 1'b0, st_val: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;
    assign bcd  = s_q.bcd;
    assign init = s_q.init;
    assign load = s_q.load;
endmodule

// File: rtl/thr_read_mux.sv
module thr_read_mux
    import thr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic [AW-1:0]                bus_addr,
    input  logic [NCH-1:0][BYTE_W-1:0]   chan_bytes,
    output logic [BYTE_W-1:0]            rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i)) rdata = chan_bytes[i];
        end
    end
endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
    import thr_pkg::*;
#(
    parameter int NCH = 3,
    localparam int AW = $clog2(NCH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output logic [BYTE_W-1:0]       bus_rdata,
    output logic [MODE_W*NCH-1:0]   chan_mode,
    output logic [NCH-1:0]          chan_bcd,
    output logic [CNT_W*NCH-1:0]    chan_init,
    output logic [NCH-1:0]          chan_load,
    input  logic [CNT_W*NCH-1:0]    chan_count,
    input  logic [NCH-1:0]          chan_out,
    input  logic [NCH-1:0]          chan_null
);
    chan_cmd_t [NCH-1:0]         cmd;
    logic [NCH-1:0][BYTE_W-1:0]  chan_bytes;

    thr_cmd_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .cmd_bits (bus_wdata[BYTE_W-1:1]),
        .cmd      (cmd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        thr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[i]),
            .wdata     (bus_wdata),
            .live_cnt  (chan_count[i*CNT_W +: CNT_W]),
            .live_out  (chan_out[i]),
            .live_null (chan_null[i]),
            .mode      (chan_mode[i*MODE_W +: MODE_W]),
            .bcd       (chan_bcd[i]),
            .init      (chan_init[i*CNT_W +: CNT_W]),
            .load      (chan_load[i]),
            .rd_byte   (chan_bytes[i])
        );
    end

    thr_read_mux #(.NCH(NCH), .AW(AW)) u_mux (
        .bus_addr   (bus_addr),
        .chan_bytes (chan_bytes),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/thr_checker.sv
module thr_checker
    import thr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_wr,
    input logic [MODE_W*NCH-1:0]  chan_mode,
    input logic [CNT_W*NCH-1:0]   chan_init,
    input logic [NCH-1:0]         chan_load
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == CTL_ADDR) |=> $stable(chan_mode)); // R2

    AST_CTL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTL_ADDR) |=> (chan_load == '0)); // R2

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(chan_init)); // R3

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_load)); // R3

    for (genvar i = 0; i < NCH; i++) begin : g_ld
        AST_LOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            chan_load[i] |-> $past(bus_wr && bus_addr == AW'(i))); // R3
    end
endmodule

bind timer_host_regs thr_checker #(.NCH(NCH), .AW(AW)) u_thr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .chan_mode (chan_mode),
    .chan_init (chan_init),
    .chan_load (chan_load)
);

// File: tb/tb_timer_host_regs.sv
module tb_timer_host_regs;
    localparam int NCH = 3;
    localparam int NV  = 53;
    // vector: {op[1:0], addr[1:0], val[15:0], exp[7:0], req[3:0]}; op 0 write, 1 read, 2 set live count
    localparam logic [31:0] VECS [NV] = '{
        {2'd1, 2'd0, 16'h0000, 8'h34, 4'd1},  // R1 reset format: live low byte
        {2'd0, 2'd3, 16'h0034, 8'h00, 4'd2},  // R2 ch0 fmt11 mode2
        {2'd0, 2'd0, 16'h0078, 8'h00, 4'd3},  // R3 ch0 low byte
        {2'd0, 2'd3, 16'h0072, 8'h00, 4'd2},  // R2 ch1 fmt11 mode1
        {2'd0, 2'd1, 16'h0011, 8'h00, 4'd4},  // R4 ch1 low (interleaved)
        {2'd0, 2'd0, 16'h0056, 8'h00, 4'd4},  // R4 ch0 high
        {2'd0, 2'd1, 16'h0022, 8'h00, 4'd4},  // R4 ch1 high
        {2'd1, 2'd0, 16'h0000, 8'h34, 4'd4},  // R4
        {2'd1, 2'd1, 16'h0000, 8'hCD, 4'd4},  // R4
        {2'd1, 2'd0, 16'h0000, 8'h12, 4'd4},  // R4
        {2'd1, 2'd1, 16'h0000, 8'hAB, 4'd4},  // R4
        {2'd0, 2'd3, 16'h0000, 8'h00, 4'd5},  // R5 latch ch0 (0x1234)
        {2'd2, 2'd0, 16'h9999, 8'h00, 4'd5},  // R5
        {2'd0, 2'd3, 16'h0000, 8'h00, 4'd6},  // R6 second latch ignored
        {2'd1, 2'd0, 16'h0000, 8'h34, 4'd6},  // R6
        {2'd2, 2'd0, 16'h8888, 8'h00, 4'd5},  // R5
        {2'd1, 2'd0, 16'h0000, 8'h12, 4'd5},  // R5
        {2'd1, 2'd0, 16'h0000, 8'h88, 4'd5},  // R5 released
        {2'd1, 2'd0, 16'h0000, 8'h88, 4'd5},  // R5
        {2'd0, 2'd3, 16'h00B7, 8'h00, 4'd2},  // R2 ch2 fmt11 mode3 bcd
        {2'd0, 2'd3, 16'h00C8, 8'h00, 4'd7},  // R7 read-back count+status ch2
        {2'd2, 2'd2, 16'h5555, 8'h00, 4'd7},  // R7
        {2'd0, 2'd3, 16'h00C8, 8'h00, 4'd7},  // R7 repeat ignored
        {2'd1, 2'd2, 16'h0000, 8'hB7, 4'd8},  // R8 status
        {2'd1, 2'd2, 16'h0000, 8'h0E, 4'd9},  // R9
        {2'd1, 2'd2, 16'h0000, 8'h0F, 4'd9},  // R9
        {2'd1, 2'd2, 16'h0000, 8'h55, 4'd9},  // R9 live
        {2'd1, 2'd2, 16'h0000, 8'h55, 4'd9},  // R9
        {2'd0, 2'd3, 16'h00D8, 8'h00, 4'd7},  // R7 count only
        {2'd2, 2'd2, 16'h6666, 8'h00, 4'd7},  // R7
        {2'd0, 2'd3, 16'h00E8, 8'h00, 4'd7},  // R7 status only, later
        {2'd1, 2'd2, 16'h0000, 8'hB7, 4'd9},  // R9 status first
        {2'd1, 2'd2, 16'h0000, 8'h55, 4'd9},  // R9
        {2'd1, 2'd2, 16'h0000, 8'h55, 4'd9},  // R9
        {2'd1, 2'd2, 16'h0000, 8'h66, 4'd9},  // R9
        {2'd1, 2'd2, 16'h0000, 8'h66, 4'd9},  // R9
        {2'd0, 2'd3, 16'h0000, 8'h00, 4'd10}, // R10 latch ch0 (0x8888)
        {2'd2, 2'd0, 16'h4321, 8'h00, 4'd10}, // R10
        {2'd1, 2'd0, 16'h0000, 8'h88, 4'd10}, // R10 half read
        {2'd0, 2'd3, 16'h0034, 8'h00, 4'd10}, // R10 reprogram
        {2'd1, 2'd0, 16'h0000, 8'h21, 4'd10}, // R10
        {2'd1, 2'd0, 16'h0000, 8'h43, 4'd10}, // R10
        {2'd0, 2'd3, 16'h0062, 8'h00, 4'd3},  // R3 ch1 high-only
        {2'd1, 2'd1, 16'h0000, 8'hAB, 4'd3},  // R3
        {2'd1, 2'd1, 16'h0000, 8'hAB, 4'd3},  // R3
        {2'd0, 2'd3, 16'h0050, 8'h00, 4'd3},  // R3 ch1 low-only
        {2'd1, 2'd1, 16'h0000, 8'hCD, 4'd3},  // R3
        {2'd1, 2'd3, 16'h0000, 8'h00, 4'd11}, // R11
        {2'd0, 2'd3, 16'h00EE, 8'h00, 4'd8},  // R8 status all three
        {2'd1, 2'd1, 16'h0000, 8'h50, 4'd8},  // R8
        {2'd1, 2'd0, 16'h0000, 8'h34, 4'd8},  // R8
        {2'd1, 2'd2, 16'h0000, 8'hB7, 4'd8},  // R8
        {2'd1, 2'd0, 16'h0000, 8'h21, 4'd4}   // R4 position intact
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;
    logic [47:0] chan_init;
    logic [2:0]  chan_load;
    logic [47:0] chan_count = {16'h0F0E, 16'hABCD, 16'h1234};
    logic [2:0]  chan_out = 3'b100;
    logic [2:0]  chan_null = 3'b010;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    timer_host_regs #(.NCH(NCH)) dut (.*);

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", {39'd0, chan_mode}, 48'd0);
        chk("R1 bcd", {45'd0, chan_bcd}, 48'd0);
        chk("R1 init", chan_init, 48'd0);
        chk("R1 load", {45'd0, chan_load}, 48'd0);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            string tag;
            e = VECS[v];
            tag = $sformatf("R%0d vec%0d", e[3:0], v);
            @(negedge clk);
            case (e[31:30])
                2'd0: begin
                    bus_addr = e[29:28]; bus_wdata = e[19:12]; bus_wr = 1'b1;
                    @(negedge clk);
                    bus_wr = 1'b0;
                end
                2'd1: begin
                    bus_addr = e[29:28]; bus_rd = 1'b1;
                    #2;
                    chk(tag, {40'd0, bus_rdata}, {40'd0, e[11:4]});
                    @(negedge clk);
                    bus_rd = 1'b0;
                end
                default: begin
                    chan_count[e[29:28]*16 +: 16] = e[27:12];
                end
            endcase
        end

        // R3 single-byte and two-byte loads on channel 0
        wr(2'd3, 8'h10);
        wr(2'd0, 8'hA5);
        chk("R3 lo load", {45'd0, chan_load}, 48'd1);
        chk("R3 lo init", {32'd0, chan_init[15:0]}, 48'h00A5);
        @(negedge clk);
        chk("R3 strobe width", {45'd0, chan_load}, 48'd0);
        wr(2'd3, 8'h20);
        wr(2'd0, 8'h5A);
        chk("R3 hi init", {32'd0, chan_init[15:0]}, 48'h5A00);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h11);
        chk("R3 first byte no load", {45'd0, chan_load}, 48'd0);
        wr(2'd0, 8'h22);
        chk("R3 second byte load", {45'd0, chan_load}, 48'd1);
        chk("R3 two-byte init", {32'd0, chan_init[15:0]}, 48'h2211);

        // R2 control word fields and isolation
        wr(2'd3, 8'h3B);
        chk("R2 mode ch0", {45'd0, chan_mode[2:0]}, 48'd5);
        chk("R2 bcd ch0", {47'd0, chan_bcd[0]}, 48'd1);
        chk("R2 mode ch1 kept", {45'd0, chan_mode[5:3]}, 48'd0);
        chk("R2 mode ch2 kept", {45'd0, chan_mode[8:6]}, 48'd3);
        chk("R2 no load", {45'd0, chan_load}, 48'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule